// File: doc/BRIEF.md
# ATA Interrupt Source Router

This block produces the host-side interrupt of a parallel ATA channel and steers it onto one of two legacy interrupt lines. Two sources can raise it: a rising edge on the attached drive's interrupt wire, which arrives asynchronously and is synchronized here, and a one-cycle strobe from the descriptor engine reporting that a descriptor with its interrupt flag set has finished. Each event latches a status bit that software clears by writing one, and fires a single-cycle, active-high pulse on the selected legacy line.

The line is chosen by the operating mode. When the channel runs on its own, every event goes to the primary line. When it shares the legacy channel pair with a second storage controller (combined mode), a two-bit mapping value says which logical channel the other controller is taking over. This channel then takes the other channel and its line. Starting a transfer clears both the interrupt status and the error status. A separate error strobe sets the error status.

Top module: `ata_irq_router`

## Requirements
- R1: After reset, `irq_pri_o`, `irq_sec_o`, `irq_sts_o` and `err_sts_o` are all 0.
- R2: A low-to-high change of `dev_irq_i` first sampled high at clock edge k raises the interrupt event at edge k+2 (default of two synchronizer stages). A level held high after that gives no further event.
- R3: `desc_done_i` and `desc_flag_i` both high at edge k raise the interrupt event at edge k. `desc_done_i` with `desc_flag_i` low raises nothing.
- R4: Each event drives a pulse exactly one clock wide and active high, on at most one of `irq_pri_o` and `irq_sec_o`. A pulse appears only while `irq_sts_o` is 1.
- R5: With `combined_i` = 0, every event pulses `irq_pri_o`, whatever `map_sel_i` holds.
- R6: With `combined_i` = 1 and `map_sel_i` = 2'd1 (the other controller takes the secondary channel), events pulse `irq_pri_o`.
- R7: With `combined_i` = 1 and `map_sel_i` = 2'd2 (the other controller takes the primary channel), events pulse `irq_sec_o`.
- R8: With `combined_i` = 1 and `map_sel_i` equal to 2'd0 or 2'd3, no pulse is driven, but `irq_sts_o` is still set.
- R9: A write (`sts_wr_i` = 1) with `sts_wdata_i[0]` = 1 clears `irq_sts_o`, and with `sts_wdata_i[1]` = 1 clears `err_sts_o`, at that edge. Bits written as 0 leave their status bit unchanged.
- R10: `xfer_start_i` = 1 clears both `irq_sts_o` and `err_sts_o` at that edge.
- R11: An interrupt event in the same cycle as a clear (write-one or start) leaves `irq_sts_o` at 1. The same rule applies to `err_evt_i` and `err_sts_o`.
- R12: `err_evt_i` = 1 at an edge sets `err_sts_o` and neither pulses a line nor touches `irq_sts_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dev_irq_i | input | 1 | Drive interrupt wire, asynchronous |
| desc_done_i | input | 1 | Descriptor finished strobe |
| desc_flag_i | input | 1 | Interrupt flag of the finished descriptor |
| err_evt_i | input | 1 | Transfer error strobe |
| xfer_start_i | input | 1 | Transfer start strobe, clears both status bits |
| sts_wr_i | input | 1 | Status write strobe |
| sts_wdata_i | input | 2 | Write-one-to-clear data: bit 0 interrupt, bit 1 error |
| combined_i | input | 1 | 1 = channel shares the legacy pair with another controller |
| map_sel_i | input | 2 | Combined-mode channel mapping value |
| irq_pri_o | output | 1 | Pulse on the primary legacy interrupt line |
| irq_sec_o | output | 1 | Pulse on the secondary legacy interrupt line |
| irq_sts_o | output | 1 | Latched interrupt status |
| err_sts_o | output | 1 | Latched error status |

## Verification
The hardest case to reach from the ports is a clear landing on the same edge as a new event. For the drive wire, the event edge sits two cycles behind the input change, so the clear has to be timed against the synchronizer delay. The directed tests place a write-one and a transfer start exactly on the event edge, once for a descriptor strobe and once two edges after a drive-wire rise. Random rounds then cover both sources under every mode and mapping value, including the two reserved mappings.

// File: rtl/ata_irq_pkg.sv
package ata_irq_pkg;
  localparam int MAP_W = 2;
  localparam logic [MAP_W-1:0] MAP_OTHER_SEC = 2'd1;
  localparam logic [MAP_W-1:0] MAP_OTHER_PRI = 2'd2;

  typedef enum logic [1:0] {
    RT_NONE = 2'd0,
    RT_PRI  = 2'd1,
    RT_SEC  = 2'd2
  } route_e;

  function automatic route_e pick_route(input logic combined,
                                        input logic [MAP_W-1:0] map);
    route_e r;
    if (!combined)               r = RT_PRI;
    else if (map == MAP_OTHER_SEC) r = RT_PRI;
    else if (map == MAP_OTHER_PRI) r = RT_SEC;
    else                         r = RT_NONE;
    return r;
  endfunction
endpackage

// File: rtl/ata_irq_edge_sync.sv
module ata_irq_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic rise_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;
  logic              prev_d;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      logic stage_d;
      if (s == 0) begin : g_first
        always_comb stage_d = async_i;
      end else begin : g_rest
        always_comb stage_d = sync_q[s-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q[s] <= 1'b0;
        else        sync_q[s] <= stage_d;
      end
    end
  endgenerate

  always_comb prev_d = sync_q[STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= prev_d;
  end

  assign rise_o = sync_q[STAGES-1] & ~prev_q;

  // R2: a held level yields one event only
  assert_single_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rise_o |=> !rise_o);
endmodule

// File: rtl/ata_irq_status.sv
module ata_irq_status (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       irq_evt_i,
  input  logic       err_evt_i,
  input  logic       start_i,
  input  logic       wr_i,
  input  logic [1:0] wdata_i,
  output logic       irq_sts_o,
  output logic       err_sts_o
);
  logic irq_q, irq_d, err_q, err_d;
  logic irq_clr, err_clr;

  always_comb begin
    irq_clr = start_i | (wr_i & wdata_i[0]);
    err_clr = start_i | (wr_i & wdata_i[1]);
    irq_d   = irq_q;
    err_d   = err_q;
    if (irq_clr) irq_d = 1'b0;
    if (irq_evt_i) irq_d = 1'b1;
    if (err_clr) err_d = 1'b0;
    if (err_evt_i) err_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q <= 1'b0;
      err_q <= 1'b0;
    end else begin
      irq_q <= irq_d;
      err_q <= err_d;
    end
  end

  assign irq_sts_o = irq_q;
  assign err_sts_o = err_q;

  assert_set_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
    irq_evt_i |=> irq_sts_o);
  assert_w1c_irq_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && wdata_i[0] && !irq_evt_i) |=> !irq_sts_o);
  assert_start_clr_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !irq_evt_i && !err_evt_i) |=> (!irq_sts_o && !err_sts_o));
  assert_err_set_R12: assert property (@(posedge clk) disable iff (!rst_n)
    err_evt_i |=> err_sts_o);
endmodule

// File: rtl/ata_irq_route.sv
module ata_irq_route
  import ata_irq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             evt_i,
  input  logic             combined_i,
  input  logic [MAP_W-1:0] map_i,
  output logic             pri_o,
  output logic             sec_o
);
  route_e rt;
  logic   pri_q, pri_d, sec_q, sec_d;

  always_comb begin
    rt    = pick_route(combined_i, map_i);
    pri_d = evt_i && (rt == RT_PRI);
    sec_d = evt_i && (rt == RT_SEC);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pri_q <= 1'b0;
      sec_q <= 1'b0;
    end else begin
      pri_q <= pri_d;
      sec_q <= sec_d;
    end
  end

  assign pri_o = pri_q;
  assign sec_o = sec_q;

  assert_one_line_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({pri_o, sec_o}));
  assert_indep_pri_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_i && !combined_i) |=> (pri_o && !sec_o));
  assert_map_sec_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_i && combined_i && map_i == MAP_OTHER_PRI) |=> (sec_o && !pri_o));
  assert_reserved_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (combined_i && (map_i == 2'd0 || map_i == 2'd3)) |=> (!pri_o && !sec_o));
endmodule

// File: rtl/ata_irq_router.sv
module ata_irq_router
  import ata_irq_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dev_irq_i,
  input  logic             desc_done_i,
  input  logic             desc_flag_i,
  input  logic             err_evt_i,
  input  logic             xfer_start_i,
  input  logic             sts_wr_i,
  input  logic [1:0]       sts_wdata_i,
  input  logic             combined_i,
  input  logic [MAP_W-1:0] map_sel_i,
  output logic             irq_pri_o,
  output logic             irq_sec_o,
  output logic             irq_sts_o,
  output logic             err_sts_o
);
  logic dev_rise;
  logic irq_evt;

  ata_irq_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i (dev_irq_i),
    .rise_o  (dev_rise)
  );

  assign irq_evt = dev_rise | (desc_done_i & desc_flag_i);

  ata_irq_status u_status (
    .clk       (clk),
    .rst_n     (rst_n),
    .irq_evt_i (irq_evt),
    .err_evt_i (err_evt_i),
    .start_i   (xfer_start_i),
    .wr_i      (sts_wr_i),
    .wdata_i   (sts_wdata_i),
    .irq_sts_o (irq_sts_o),
    .err_sts_o (err_sts_o)
  );

  ata_irq_route u_route (
    .clk        (clk),
    .rst_n      (rst_n),
    .evt_i      (irq_evt),
    .combined_i (combined_i),
    .map_i      (map_sel_i),
    .pri_o      (irq_pri_o),
    .sec_o      (irq_sec_o)
  );

  // R4: a pulse is never without latched status
  assert_pulse_has_sts_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_pri_o || irq_sec_o) |-> irq_sts_o);
  // R3: a descriptor finishing without its flag changes nothing
  assert_noflag_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (desc_done_i && !desc_flag_i && !dev_rise && !irq_sts_o
     && !err_evt_i) |=> !irq_sts_o);
endmodule

// File: tb/test_ata_irq_router.sv
module test_ata_irq_router;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       dev_irq, desc_done, desc_flag, err_evt, start, wr;
  logic [1:0] wdata, map;
  logic       combined;
  logic       pri, sec, irq_sts, err_sts;

  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ata_irq_router i_ata_irq_router (
    .clk(clk), .rst_n(rst_n), .dev_irq_i(dev_irq), .desc_done_i(desc_done),
    .desc_flag_i(desc_flag), .err_evt_i(err_evt), .xfer_start_i(start),
    .sts_wr_i(wr), .sts_wdata_i(wdata), .combined_i(combined),
    .map_sel_i(map), .irq_pri_o(pri), .irq_sec_o(sec),
    .irq_sts_o(irq_sts), .err_sts_o(err_sts)
  );

  // expected line: 1 = primary, 2 = secondary, 0 = none
  function automatic int exp_line(input logic c, input logic [1:0] m);
    if (!c) return 1;
    if (m == 2'd1) return 1;
    if (m == 2'd2) return 2;
    return 0;
  endfunction

  function automatic string line_req(input logic c, input logic [1:0] m);
    if (!c) return "R5";
    if (m == 2'd1) return "R6";
    if (m == 2'd2) return "R7";
    return "R8";
  endfunction

  task automatic chk(input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic idle_in();
    dev_irq = 0; desc_done = 0; desc_flag = 0; err_evt = 0;
    start = 0; wr = 0; wdata = 2'b00;
  endtask

  task automatic clear_all();
    @(negedge clk); wr = 1; wdata = 2'b11;
    @(negedge clk); wr = 0; wdata = 2'b00;
  endtask

  // called at a negedge; returns at the negedge after the event edge
  task automatic fire_desc(input logic c, input logic [1:0] m);
    combined = c; map = m; desc_done = 1; desc_flag = 1;
    @(negedge clk); desc_done = 0; desc_flag = 0;
  endtask

  task automatic fire_dev(input logic c, input logic [1:0] m, input string req);
    combined = c; map = m; dev_irq = 1;
    @(negedge clk);
    @(negedge clk);
    chk(req, "no pulse before sync delay", pri | sec, 0);
    @(negedge clk);
  endtask

  task automatic check_pulse(input logic c, input logic [1:0] m);
    int e;
    string rq;
    e  = exp_line(c, m);
    rq = line_req(c, m);
    chk(rq, "primary line", pri, e == 1);
    chk(rq, "secondary line", sec, e == 2);
    chk("R4", "status with pulse", irq_sts, 1);
    @(negedge clk);
    chk("R4", "pulse width one cycle", pri | sec, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_fail++; n_chk++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_A7A1));
    idle_in(); combined = 0; map = 0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    chk("R1", "pri after reset", pri, 0);
    chk("R1", "sec after reset", sec, 0);
    chk("R1", "irq_sts after reset", irq_sts, 0);
    chk("R1", "err_sts after reset", err_sts, 0);
    rst_n = 1;
    @(negedge clk);

    // R3: descriptor without flag
    desc_done = 1; desc_flag = 0;
    @(negedge clk); desc_done = 0;
    chk("R3", "no status without flag", irq_sts, 0);
    chk("R3", "no pulse without flag", pri | sec, 0);

    // R3 / R5: descriptor with flag, independent mode, map ignored
    fire_desc(0, 2'd2);
    check_pulse(0, 2'd2);
    chk("R3", "status held", irq_sts, 1);

    // R9: writing zeros keeps status, bit0 clears
    wr = 1; wdata = 2'b00; @(negedge clk);
    chk("R9", "zero write keeps irq_sts", irq_sts, 1);
    wdata = 2'b10; @(negedge clk);
    chk("R9", "bit1 write keeps irq_sts", irq_sts, 1);
    wdata = 2'b01; @(negedge clk); wr = 0; wdata = 0;
    chk("R9", "bit0 write clears irq_sts", irq_sts, 0);

    // R2: drive-wire rise, combined map 2 -> secondary
    fire_dev(1, 2'd2, "R2");
    chk("R2", "status after sync", irq_sts, 1);
    check_pulse(1, 2'd2);
    repeat (4) begin
      @(negedge clk);
      chk("R2", "held level no new pulse", pri | sec, 0);
    end
    dev_irq = 0; repeat (3) @(negedge clk);
    clear_all();

    // R8: reserved maps set status without pulse
    fire_desc(1, 2'd0);
    chk("R8", "map0 no pulse", pri | sec, 0);
    chk("R8", "map0 status set", irq_sts, 1);
    clear_all();
    fire_desc(1, 2'd3);
    chk("R8", "map3 no pulse", pri | sec, 0);
    chk("R8", "map3 status set", irq_sts, 1);
    clear_all();

    // R6
    fire_desc(1, 2'd1);
    check_pulse(1, 2'd1);
    clear_all();

    // R12: error strobe
    err_evt = 1; @(negedge clk); err_evt = 0;
    chk("R12", "err_sts set", err_sts, 1);
    chk("R12", "irq_sts untouched", irq_sts, 0);
    chk("R12", "no pulse on error", pri | sec, 0);
    wr = 1; wdata = 2'b01; @(negedge clk); wr = 0; wdata = 0;
    chk("R9", "bit0 write keeps err_sts", err_sts, 1);
    wr = 1; wdata = 2'b10; @(negedge clk); wr = 0; wdata = 0;
    chk("R9", "bit1 write clears err_sts", err_sts, 0);

    // R10: start clears both
    err_evt = 1; @(negedge clk); err_evt = 0;
    fire_desc(0, 2'd0);
    @(negedge clk);
    start = 1; @(negedge clk); start = 0;
    chk("R10", "start clears irq_sts", irq_sts, 0);
    chk("R10", "start clears err_sts", err_sts, 0);

    // R11: event same cycle as clear write
    fire_desc(0, 2'd0);
    combined = 0; desc_done = 1; desc_flag = 1; wr = 1; wdata = 2'b11;
    err_evt = 1;
    @(negedge clk); idle_in();
    chk("R11", "desc event beats w1c", irq_sts, 1);
    chk("R11", "err event beats w1c", err_sts, 1);
    // R11: drive-wire event on the same edge as start
    combined = 0; dev_irq = 1;
    @(negedge clk); @(negedge clk);
    start = 1; @(negedge clk); start = 0;
    chk("R11", "dev event beats start", irq_sts, 1);
    chk("R10", "start clears err_sts", err_sts, 0);
    chk("R5", "pulse on start edge", pri, 1);
    dev_irq = 0; repeat (3) @(negedge clk);
    clear_all();

    // random rounds
    for (int i = 0; i < 200; i++) begin
      logic c;
      logic [1:0] m;
      c = 1'($urandom);
      m = 2'($urandom);
      if (($urandom % 2) == 0) begin
        fire_desc(c, m);
      end else begin
        fire_dev(c, m, "R2");
      end
      chk("R2", "random status set", irq_sts, 1);
      check_pulse(c, m);
      dev_irq = 0;
      repeat (3) @(negedge clk);
      chk("R4", "no stray pulse", pri | sec, 0);
      if (($urandom % 2) == 0) begin
        clear_all();
        chk("R9", "random clear", irq_sts, 0);
      end else begin
        start = 1; @(negedge clk); start = 0;
        chk("R10", "random start clear", irq_sts, 0);
      end
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule